// File: doc/BRIEF.md
# Multi-Channel Reloadable Timer Bank

The block holds four counters behind a plain register port (address, write data, write strobe, combinational read data). Three of them are down-counters: the first two are 16 bits wide and the third is 32 bits wide. Each counts on a tick strobe chosen per channel, reloads itself or wraps at underflow, and raises a level interrupt that stays up until software writes that channel's clear register. The fourth counter is a 40-bit up-counting timestamp. It runs on its own faster tick strobe, never reloads and never interrupts.

Software programs a period of N ticks by stopping a channel, writing N-1 to its load register, and then setting the run bit in its control register. Because a load written while the channel is stopped also goes into the counter, the first period after start is exact. The timestamp starts when its enable bit is set in its high word and is read as a low word and a high word. All tick strobes come from outside the block and are one clock wide.

Top module: `tmr_bank`

## Requirements
- R1: After reset every load value, counter, control field, interrupt and the timestamp (count and enable) read back as zero.
- R2: Control register bits: bit 7 = run, bit 6 = periodic, bit 3 = fast tick select. They read back at those positions and every other bit reads as 0. A channel does not count while bit 7 is clear.
- R3: A load write while the channel is stopped also sets its counter to the written value. A load write while the channel runs changes only the load register.
- R4: A running channel decrements by one on each selected tick. In periodic mode, a tick at count 0 reloads the load value and sets the interrupt, so a load of N-1 gives an interrupt every N ticks.
- R5: When bit 6 is clear, a tick at count 0 wraps the counter to all ones of the channel width and sets the interrupt.
- R6: An interrupt stays asserted until any write to the channel's clear register. If an underflow falls in the same cycle as a clear write, the interrupt stays set. irq bit i belongs to channel i.
- R7: With bit 3 set, a channel counts on tick_fast and ignores tick_slow. With bit 3 clear, it counts on tick_slow and ignores tick_fast.
- R8: Channels 0 and 1 hold 16 bits and channel 2 holds 32 bits. Written bits above the width are dropped and read back as zero.
- R9: Writing the timestamp high word with bit 8 set enables the timestamp, which then counts up by one per tick_ts. The low word reads count bits 31:0. The high word reads the enable in bit 8 and count bits 39:32 in bits 7:0.
- R10: Writing the timestamp high word with bit 8 clear stops the count and sets it to zero.
- R11: Address map. Channel i sits at 0x20*i: load at +0x00, value at +0x04, control at +0x08, clear at +0x0C. The timestamp low word is at 0x60 and the high word at 0x64. Offsets +0x10..+0x1C of each channel read as zero and ignore writes, and a write to one channel does not change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Byte address of the register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_fast | input | 1 | Fast down-count tick strobe |
| tick_slow | input | 1 | Slow down-count tick strobe |
| tick_ts | input | 1 | Timestamp tick strobe |
| irq | output | 3 | Level interrupts, bit i for channel i |

## Verification
The assertions assume that each tick strobe is a single-cycle pulse sampled on the clock, and that a register write lasts exactly one cycle with a stable address. The properties about reload and holding a stopped count also assume that no load write lands in the cycle being checked, so they exclude that case explicitly. The bench drives every strobe and write for exactly one clock, starting at the falling edge. It restarts each channel from a stopped state before each table vector, and places the single overlap of an underflow with a clear write in a directed test, where the expected outcome is known.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W    = 32;
    localparam int CB_RUN    = 7;
    localparam int CB_PER    = 6;
    localparam int CB_FAST   = 3;
    localparam int TS_EN_BIT = 8;

    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_VALUE = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLEAR = 2'd3
    } chan_sel_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_ctrl,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  chan_sel_e         rd_sel,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    typedef struct packed {
        logic [W-1:0] load;
        logic [W-1:0] cnt;
        logic         run;
        logic         per;
        logic         fast;
        logic         irq;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic     tick_pick, step, under;

    always_comb begin
        tick_pick = st_q.fast ? tick_fast : tick_slow;
        step      = st_q.run && tick_pick;
        under     = step && (st_q.cnt == '0);
        st_d      = st_q;
        if (wr_load) begin
            st_d.load = wdata[W-1:0];
            if (!st_q.run) st_d.cnt = wdata[W-1:0];
        end
        if (step) begin
            if (under) st_d.cnt = st_q.per ? st_q.load : '1;
            else       st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_ctrl) begin
            st_d.run  = wdata[CB_RUN];
            st_d.per  = wdata[CB_PER];
            st_d.fast = wdata[CB_FAST];
        end
        if (wr_clr) st_d.irq = 1'b0;
        if (under)  st_d.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (rd_sel)
            SEL_LOAD:  rdata = DATA_W'(st_q.load);
            SEL_VALUE: rdata = DATA_W'(st_q.cnt);
            SEL_CTRL: begin
                rdata[CB_RUN]  = st_q.run;
                rdata[CB_PER]  = st_q.per;
                rdata[CB_FAST] = st_q.fast;
            end
            default:   rdata = '0;
        endcase
    end

    assign irq = st_q.irq;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_clr) |=> irq); // R6
    AST_UNDER_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick_pick && st_q.cnt == '0) |=> irq); // R4
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !wr_load) |=> $stable(st_q.cnt)); // R2
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.per && tick_pick && st_q.cnt == '0 && !wr_load)
        |=> (st_q.cnt == $past(st_q.load))); // R4
    AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !st_q.per && tick_pick && st_q.cnt == '0)
        |=> (st_q.cnt == '1)); // R5
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp
    import tmr_pkg::*;
#(
    parameter int W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              rd_hi,
    output logic [DATA_W-1:0] rdata
);
    localparam int HI_W = W - DATA_W;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         en;
    } ts_st_t;

    ts_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.en && tick) st_d.cnt = st_q.cnt + 1'b1;
        if (wr_hi) begin
            st_d.en = wdata[TS_EN_BIT];
            if (!wdata[TS_EN_BIT]) st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_hi) begin
            rdata[HI_W-1:0]  = st_q.cnt[W-1:DATA_W];
            rdata[TS_EN_BIT] = st_q.en;
        end else begin
            rdata = st_q.cnt[DATA_W-1:0];
        end
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && tick && !wr_hi) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R9
    AST_TS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_hi) |=> $stable(st_q.cnt)); // R9
    AST_TS_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wdata[TS_EN_BIT]) |=> (st_q.cnt == '0 && !st_q.en)); // R10
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int STAMP_W  = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tick_fast,
    input  logic        tick_slow,
    input  logic        tick_ts,
    output logic [2:0]  irq
);
    localparam int NCH     = 3;
    localparam int TS_SLOT = 3;

    logic [1:0]        slot;
    logic              in_win;
    chan_sel_e         sel;
    logic [DATA_W-1:0] ch_rdata [NCH];
    logic [DATA_W-1:0] ts_rdata;
    logic              ts_wr_hi, ts_rd_hi, ts_hit;

    assign slot   = reg_addr[6:5];
    assign in_win = !reg_addr[4];
    assign sel    = chan_sel_e'(reg_addr[3:2]);
    assign ts_hit = (slot == 2'(TS_SLOT)) && in_win && (reg_addr[3] == 1'b0);
    assign ts_rd_hi = reg_addr[2];
    assign ts_wr_hi = reg_wr && ts_hit && reg_addr[2];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int CW = (i == NCH - 1) ? WIDE_W : NARROW_W;
        logic hit;
        assign hit = (slot == 2'(i)) && in_win && reg_wr;
        tmr_chan #(.W(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_load   (hit && sel == SEL_LOAD),
            .wr_ctrl   (hit && sel == SEL_CTRL),
            .wr_clr    (hit && sel == SEL_CLEAR),
            .wdata     (reg_wdata),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .rd_sel    (sel),
            .rdata     (ch_rdata[i]),
            .irq       (irq[i])
        );
    end

    tmr_stamp #(.W(STAMP_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (ts_wr_hi),
        .wdata (reg_wdata),
        .tick  (tick_ts),
        .rd_hi (ts_rd_hi),
        .rdata (ts_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        if (in_win) begin
            if (slot == 2'(TS_SLOT)) begin
                if (ts_hit) reg_rdata = ts_rdata;
            end else begin
                reg_rdata = ch_rdata[slot];
            end
        end
    end

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_fast && !tick_slow) |=> ($countones(irq & ~$past(irq)) == 0)); // R6
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_fast = 1'b0, tick_slow = 1'b0, tick_ts = 1'b0;
    logic [2:0]  irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tmr_bank u_tmr_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .tick_ts(tick_ts), .irq(irq)
    );

    // {channel, load, ticks, expected value, expected irq}
    localparam logic [74:0] VECS [0:6] = '{
        {2'd0, 32'd5,          8'd3, 32'd2,          1'b0},
        {2'd0, 32'd5,          8'd6, 32'd5,          1'b1},
        {2'd1, 32'd0,          8'd1, 32'd0,          1'b1},
        {2'd1, 32'd3,          8'd9, 32'd2,          1'b1},
        {2'd0, 32'h0000FFFF,   8'd2, 32'h0000FFFD,   1'b0},
        {2'd2, 32'h12345678,   8'd2, 32'h12345676,   1'b0},
        {2'd2, 32'd10,         8'd0, 32'd10,         1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            case (which)
                0: tick_fast = 1'b1;
                1: tick_slow = 1'b1;
                default: tick_ts = 1'b1;
            endcase
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0; tick_ts = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [6:0]  base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 3; c++) begin
            for (int r = 0; r < 3; r++) begin
                rd(7'(c * 32 + r * 4), v);
                check("R1 reset reg", v, 32'h0);
            end
        end
        rd(7'h60, v); check("R1 reset ts low", v, 32'h0);
        rd(7'h64, v); check("R1 reset ts high", v, 32'h0);
        check("R1 reset irq", 32'(irq), 32'h0);

        // R4 table of periodic runs (also R3 stopped-load copy, R8 channel widths)
        for (int i = 0; i < 7; i++) begin
            logic [1:0]  ch;
            logic [31:0] ld, ev;
            logic [7:0]  nt;
            logic        ei;
            {ch, ld, nt, ev, ei} = VECS[i];
            base = 7'(ch * 32);
            wr(base + 7'h08, 32'h48);
            wr(base + 7'h0C, 32'h0);
            wr(base + 7'h00, ld);
            wr(base + 7'h08, 32'hC8);
            pulse(0, int'(nt));
            rd(base + 7'h04, v);
            check("R4 table value", v, ev);
            check("R4 table irq", 32'(irq[ch]), 32'(ei));
        end

        // R2 stopped with 0x48, readback encoding
        wr(7'h08, 32'h48); wr(7'h0C, 0); wr(7'h00, 32'd9);
        pulse(0, 3);
        rd(7'h04, v); check("R2 stopped no count", v, 32'd9);
        rd(7'h08, v); check("R2 ctrl readback", v, 32'h48);
        wr(7'h08, 32'hFFFF_FFFF);
        rd(7'h08, v); check("R2 ctrl other bits zero", v, 32'hC8);

        // R3 load write while running keeps counter
        wr(7'h08, 32'hC8);
        wr(7'h00, 32'd7);
        rd(7'h04, v); check("R3 running load no copy", v, 32'd9);
        rd(7'h00, v); check("R3 running load reg", v, 32'd7);

        // R5 free-run wrap, 16 and 32 bit
        wr(7'h28, 32'h08); wr(7'h2C, 0); wr(7'h20, 32'd1); wr(7'h28, 32'h88);
        pulse(0, 2);
        rd(7'h24, v); check("R5 wrap 16b", v, 32'h0000FFFF);
        check("R5 wrap irq", 32'(irq[1]), 32'd1);
        wr(7'h48, 32'h08); wr(7'h4C, 0); wr(7'h40, 32'd0); wr(7'h48, 32'h88);
        pulse(0, 1);
        rd(7'h44, v); check("R5 wrap 32b", v, 32'hFFFF_FFFF);

        // R6 sticky irq, clear, clear-vs-underflow
        pulse(0, 3);
        check("R6 irq held", 32'(irq[1]), 32'd1);
        wr(7'h2C, 32'h5A);
        check("R6 cleared", 32'(irq[1]), 32'd0);
        wr(7'h08, 32'h48); wr(7'h0C, 0); wr(7'h00, 32'd0); wr(7'h08, 32'hC8);
        @(negedge clk);
        reg_addr = 7'h0C; reg_wdata = 0; reg_wr = 1'b1; tick_fast = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_fast = 1'b0;
        check("R6 underflow beats clear", 32'(irq[0]), 32'd1);
        wr(7'h0C, 0);
        check("R6 clear alone", 32'(irq[0]), 32'd0);

        // R7 tick select
        wr(7'h08, 32'h40); wr(7'h00, 32'd5); wr(7'h08, 32'hC0);
        pulse(0, 2);
        rd(7'h04, v); check("R7 fast ignored", v, 32'd5);
        pulse(1, 2);
        rd(7'h04, v); check("R7 slow counts", v, 32'd3);
        wr(7'h08, 32'hC8);
        pulse(1, 2);
        rd(7'h04, v); check("R7 slow ignored", v, 32'd3);

        // R8 width truncation
        wr(7'h28, 32'h0); wr(7'h20, 32'h0001_2345);
        rd(7'h20, v); check("R8 16b load", v, 32'h2345);
        rd(7'h24, v); check("R8 16b value", v, 32'h2345);

        // R11 hole and isolation
        wr(7'h30, 32'hFFFF_FFFF);
        rd(7'h30, v); check("R11 hole reads zero", v, 32'h0);
        rd(7'h20, v); check("R11 hole write ignored", v, 32'h2345);
        rd(7'h40, v); check("R11 channel isolation", v, 32'h0);

        // R9 timestamp
        wr(7'h64, 32'h100);
        pulse(2, 5);
        rd(7'h60, v); check("R9 ts low", v, 32'd5);
        rd(7'h64, v); check("R9 ts high", v, 32'h100);
        pulse(0, 2);
        rd(7'h60, v); check("R9 ts other tick ignored", v, 32'd5);

        // R10 disable clears
        wr(7'h64, 32'h0);
        rd(7'h60, v); check("R10 ts low zero", v, 32'h0);
        rd(7'h64, v); check("R10 ts high zero", v, 32'h0);
        pulse(2, 3);
        rd(7'h60, v); check("R10 ts halted", v, 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule